// File: doc/BRIEF.md
# Line Merge Buffer

This block assembles the final contents of one cache line while a single transaction on that line is open. When a request opens the entry, the line is copied out of a small local line store. A byte-masked write-through, an atomic add, dirty probe data and memory read data may then each shape the line in turn. The block keeps the line buffer, a per-byte mask and three flags: dirty, write-through pending and atomic pending. Each arriving source is folded into the buffer by a fixed set of merge rules.

On retirement the block writes the merged outcome back into the line store. A write-through writes only its masked bytes. An atomic adds its operand into the stored line, word by word, under the mask. A plain transaction writes the buffer back only when the buffer is still clean. A combinational read port shows the buffer once memory data has been seen for the open line, and the stored line otherwise.

Only one event is taken per cycle. While the entry is open, retirement wins over probe data, and probe data wins over memory data.

Top module: `line_merge_unit`

## Requirements
- R1: After reset the entry is closed (`busy` low) and every stored line reads as zero.
- R2: Opening the entry is possible only while `busy` is low. It copies the addressed stored line into the buffer with dirty clear, and `busy` rises on the following cycle. `alloc_kind` 2'b00 means plain, 2'b01 means write-through, 2'b10 means atomic, and 2'b11 is treated as plain.
- R3: A write-through open overlays the bytes of `alloc_data` whose `alloc_mask` bit is set (byte b is bits 8b+7..8b). It keeps the mask and marks the buffer dirty.
- R4: An atomic open keeps the mask and holds `alloc_data` as the operand. The buffer and the stored line are not altered until retirement.
- R5: Dirty probe data received while a write-through is pending makes the buffer equal to the probe line with the write-through bytes on top, and the mask becomes all ones.
- R6: Dirty probe data received while the buffer is dirty and neither a write-through nor an atomic is pending leaves the buffer unchanged. Such data must equal the buffer.
- R7: Dirty probe data received while the buffer is clean replaces the buffer and sets dirty. Probe data with `prb_dirty` low has no effect.
- R8: Memory data always marks memory as seen. It replaces the buffer only when no write-through is pending and the buffer is clean.
- R9: `rd_data` shows the buffer when the entry is open, memory has been seen and `rd_idx` matches the open line. In every other case it shows the stored line at `rd_idx`.
- R10: Retiring a write-through writes only the masked buffer bytes into the stored line.
- R11: Retiring an atomic adds each 32-bit operand word, modulo 2^32, into the matching stored word when any of that word's four mask bits is set (word w is bits 32w+31..32w). Other words are kept.
- R12: Retiring a plain transaction writes the buffer to the stored line only when the buffer is clean. A dirty buffer leaves the stored line unchanged.
- R13: Probe, memory and retire inputs have no effect while the entry is closed, and a second open request is ignored while it is open.
- R14: After a write-through has merged with dirty probe data, retirement writes the whole merged line, because the mask is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_vld | input | 1 | Open the entry |
| alloc_kind | input | 2 | 00 plain, 01 write-through, 10 atomic |
| alloc_idx | input | 2 | Stored line to work on |
| alloc_mask | input | 64 | Byte mask of the write or atomic |
| alloc_data | input | 512 | Write bytes or atomic operand |
| prb_vld | input | 1 | Probe response arrives |
| prb_dirty | input | 1 | Probe response carries dirty data |
| prb_data | input | 512 | Probe line |
| mem_vld | input | 1 | Memory read data arrives |
| mem_data | input | 512 | Memory line |
| retire_vld | input | 1 | Close the entry and write back |
| rd_idx | input | 2 | Read port line select |
| rd_data | output | 512 | Read port line |
| busy | output | 1 | Entry open |

## Verification
The assertions assume the block's inputs follow two rules. First, at most one of probe, memory and retire is valid in a cycle. Second, dirty probe data that meets an already dirty plain buffer carries exactly the buffered line. The stimulus keeps to both rules: every event comes from its own task, one event per cycle, and each repeated dirty probe reuses the line the bench model already holds. The expected lines come from a bench model of the stored lines and the open entry, built from the merge rules. They are compared at the read port, so the model reveals the buffer only after memory data has been seen.

// File: rtl/line_merge_unit.sv
module line_merge_unit #(
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 4,
  parameter int LINES      = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_vld,
  input  logic [1:0]                   alloc_kind,
  input  logic [$clog2(LINES)-1:0]     alloc_idx,
  input  logic [LINE_BYTES-1:0]        alloc_mask,
  input  logic [LINE_BYTES*8-1:0]      alloc_data,
  input  logic                         prb_vld,
  input  logic                         prb_dirty,
  input  logic [LINE_BYTES*8-1:0]      prb_data,
  input  logic                         mem_vld,
  input  logic [LINE_BYTES*8-1:0]      mem_data,
  input  logic                         retire_vld,
  input  logic [$clog2(LINES)-1:0]     rd_idx,
  output logic [LINE_BYTES*8-1:0]      rd_data,
  output logic                         busy
);
  localparam int LW = LINE_BYTES * 8;
  localparam int WW = WORD_BYTES * 8;
  localparam int NW = LINE_BYTES / WORD_BYTES;
  localparam int IW = $clog2(LINES);

  logic [LW-1:0]         store_q [LINES];
  logic [LW-1:0]         buf_q, opnd_q;
  logic [LINE_BYTES-1:0] mask_q;
  logic                  act_q, dirty_q, wt_q, at_q, mem_q;
  logic [IW-1:0]         idx_q;

  function automatic logic [LW-1:0] overlay(input logic [LW-1:0] base,
                                            input logic [LW-1:0] top,
                                            input logic [LINE_BYTES-1:0] m);
    logic [LW-1:0] r;
    for (int b = 0; b < LINE_BYTES; b++)
      r[8*b +: 8] = m[b] ? top[8*b +: 8] : base[8*b +: 8];
    return r;
  endfunction

  function automatic logic [LW-1:0] add_words(input logic [LW-1:0] base,
                                              input logic [LW-1:0] opnd,
                                              input logic [LINE_BYTES-1:0] m);
    logic [LW-1:0] r;
    for (int w = 0; w < NW; w++)
      r[WW*w +: WW] = (|m[WORD_BYTES*w +: WORD_BYTES])
                      ? base[WW*w +: WW] + opnd[WW*w +: WW]
                      : base[WW*w +: WW];
    return r;
  endfunction

  wire              open_go  = !act_q && alloc_vld;
  wire              k_wt     = alloc_kind == 2'b01;
  wire              k_at     = alloc_kind == 2'b10;
  wire              ret_go   = act_q && retire_vld;
  wire              prb_go   = act_q && !retire_vld && prb_vld && prb_dirty;
  wire              mem_go   = act_q && !retire_vld && !(prb_vld && prb_dirty) && mem_vld;
  wire [LW-1:0]     cur_line = store_q[idx_q];
  wire [LW-1:0]     new_line = store_q[alloc_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) store_q[i] <= '0;
    end else if (ret_go) begin
      if (wt_q)          store_q[idx_q] <= overlay(cur_line, buf_q, mask_q);
      else if (at_q)     store_q[idx_q] <= add_words(cur_line, opnd_q, mask_q);
      else if (!dirty_q) store_q[idx_q] <= buf_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      dirty_q <= 1'b0;
      wt_q    <= 1'b0;
      at_q    <= 1'b0;
      mem_q   <= 1'b0;
      idx_q   <= '0;
      mask_q  <= '0;
      buf_q   <= '0;
      opnd_q  <= '0;
    end else if (open_go) begin
      act_q   <= 1'b1;
      idx_q   <= alloc_idx;
      wt_q    <= k_wt;
      at_q    <= k_at;
      dirty_q <= k_wt;
      mem_q   <= 1'b0;
      mask_q  <= (k_wt || k_at) ? alloc_mask : '0;
      buf_q   <= k_wt ? overlay(new_line, alloc_data, alloc_mask) : new_line;
      opnd_q  <= alloc_data;
    end else if (ret_go) begin
      act_q <= 1'b0;
    end else if (prb_go) begin
      if (wt_q) begin
        buf_q  <= overlay(prb_data, buf_q, mask_q);
        mask_q <= '1;
      end else if (!dirty_q) begin
        buf_q   <= prb_data;
        dirty_q <= 1'b1;
      end
    end else if (mem_go) begin
      mem_q <= 1'b1;
      if (!wt_q && !dirty_q) buf_q <= mem_data;
    end
  end

  assign rd_data = (act_q && mem_q && rd_idx == idx_q) ? buf_q : store_q[rd_idx];
  assign busy    = act_q;
endmodule

module line_merge_unit_chk #(
  parameter int LINE_BYTES = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    alloc_vld,
  input logic [1:0]              alloc_kind,
  input logic                    prb_vld,
  input logic                    prb_dirty,
  input logic [LINE_BYTES*8-1:0] prb_data,
  input logic                    mem_vld,
  input logic                    retire_vld,
  input logic                    act_q,
  input logic                    dirty_q,
  input logic                    wt_q,
  input logic                    at_q,
  input logic                    mem_q,
  input logic [LINE_BYTES-1:0]   mask_q,
  input logic [LINE_BYTES*8-1:0] buf_q
);
  a_r13_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prb_vld, mem_vld, retire_vld}));

  a_r6_probe_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !retire_vld && prb_vld && prb_dirty && dirty_q && !wt_q && !at_q
    |-> prb_data == buf_q);

  a_r6_buffer_kept: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !retire_vld && prb_vld && prb_dirty && dirty_q && !wt_q && !at_q
    |=> $stable(buf_q));

  a_r5_mask_full: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !retire_vld && prb_vld && prb_dirty && wt_q |=> &mask_q);

  a_r8_mem_seen: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !retire_vld && !prb_vld && mem_vld |=> mem_q);

  a_r8_mem_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !retire_vld && !prb_vld && mem_vld && (wt_q || dirty_q) |=> $stable(buf_q));

  a_r3_wt_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q && alloc_vld && alloc_kind == 2'b01 |=> act_q && dirty_q && wt_q);

  a_r13_stays_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q && !alloc_vld |=> !act_q);

  a_r7_dirty_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && dirty_q && !retire_vld |=> dirty_q);
endmodule

bind line_merge_unit line_merge_unit_chk #(.LINE_BYTES(LINE_BYTES)) u_chk (.*);

// File: tb/test_line_merge_unit.sv
module test_line_merge_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         alloc_vld = 1'b0;
  logic [1:0]   alloc_kind = '0;
  logic [1:0]   alloc_idx = '0;
  logic [63:0]  alloc_mask = '0;
  logic [511:0] alloc_data = '0;
  logic         prb_vld = 1'b0, prb_dirty = 1'b0;
  logic [511:0] prb_data = '0;
  logic         mem_vld = 1'b0;
  logic [511:0] mem_data = '0;
  logic         retire_vld = 1'b0;
  logic [1:0]   rd_idx = '0;
  logic [511:0] rd_data;
  logic         busy;

  always #5 clk = ~clk;

  line_merge_unit i_line_merge_unit (.*);

  int total = 0, bad = 0;
  logic         smp = 1'b0;
  logic [511:0] exp_q[$];
  string        req_q[$];

  logic [511:0] m_store [4];
  logic [511:0] m_buf, m_opnd;
  logic [63:0]  m_mask;
  logic         m_act, m_dirty, m_wt, m_at, m_mem;
  logic [1:0]   m_idx;

  function automatic logic [511:0] pat(input int s);
    logic [511:0] r;
    for (int w = 0; w < 16; w++) r[32*w +: 32] = s * 32'h0100_0193 + w * 32'h9E37_79B9 + 32'h11;
    return r;
  endfunction

  function automatic logic [511:0] ovl(input logic [511:0] b, input logic [511:0] t, input logic [63:0] m);
    logic [511:0] r;
    for (int i = 0; i < 64; i++) r[8*i +: 8] = m[i] ? t[8*i +: 8] : b[8*i +: 8];
    return r;
  endfunction

  function automatic logic [511:0] addw(input logic [511:0] b, input logic [511:0] o, input logic [63:0] m);
    logic [511:0] r;
    for (int w = 0; w < 16; w++) r[32*w +: 32] = (|m[4*w +: 4]) ? b[32*w +: 32] + o[32*w +: 32] : b[32*w +: 32];
    return r;
  endfunction

  always @(negedge clk) begin
    if (smp) begin
      logic [511:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      total++;
      if (rd_data !== e) begin
        bad++;
        $display("FAIL %s rd_data=%h expected=%h", r, rd_data, e);
      end
    end
  end

  task automatic do_alloc(input logic [1:0] k, input logic [1:0] idx, input logic [63:0] m, input logic [511:0] d);
    @(posedge clk); #1;
    alloc_vld = 1'b1; alloc_kind = k; alloc_idx = idx; alloc_mask = m; alloc_data = d;
    if (!m_act) begin
      m_act = 1'b1; m_idx = idx; m_mem = 1'b0;
      m_wt = (k == 2'b01); m_at = (k == 2'b10); m_dirty = m_wt;
      m_mask = (m_wt || m_at) ? m : '0;
      m_buf = m_wt ? ovl(m_store[idx], d, m) : m_store[idx];
      m_opnd = d;
    end
    @(posedge clk); #1;
    alloc_vld = 1'b0;
  endtask

  task automatic do_probe(input logic dty, input logic [511:0] d);
    @(posedge clk); #1;
    prb_vld = 1'b1; prb_dirty = dty; prb_data = d;
    if (m_act && dty) begin
      if (m_wt) begin m_buf = ovl(d, m_buf, m_mask); m_mask = '1; end
      else if (!m_dirty) begin m_buf = d; m_dirty = 1'b1; end
    end
    @(posedge clk); #1;
    prb_vld = 1'b0; prb_dirty = 1'b0;
  endtask

  task automatic do_mem(input logic [511:0] d);
    @(posedge clk); #1;
    mem_vld = 1'b1; mem_data = d;
    if (m_act) begin
      m_mem = 1'b1;
      if (!m_wt && !m_dirty) m_buf = d;
    end
    @(posedge clk); #1;
    mem_vld = 1'b0;
  endtask

  task automatic do_retire();
    @(posedge clk); #1;
    retire_vld = 1'b1;
    if (m_act) begin
      if (m_wt)          m_store[m_idx] = ovl(m_store[m_idx], m_buf, m_mask);
      else if (m_at)     m_store[m_idx] = addw(m_store[m_idx], m_opnd, m_mask);
      else if (!m_dirty) m_store[m_idx] = m_buf;
      m_act = 1'b0;
    end
    @(posedge clk); #1;
    retire_vld = 1'b0;
  endtask

  task automatic expect_rd(input logic [1:0] idx, input string req);
    @(posedge clk); #1;
    rd_idx = idx;
    exp_q.push_back((m_act && m_mem && idx == m_idx) ? m_buf : m_store[idx]);
    req_q.push_back(req);
    smp = 1'b1;
    @(posedge clk); #1;
    smp = 1'b0;
  endtask

  task automatic expect_busy(input logic e, input string req);
    @(negedge clk);
    total++;
    if (busy !== e) begin
      bad++;
      $display("FAIL %s busy=%0b expected=%0b", req, busy, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_store[i] = '0;
    m_buf = '0; m_opnd = '0; m_mask = '0; m_idx = '0;
    m_act = 0; m_dirty = 0; m_wt = 0; m_at = 0; m_mem = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    expect_busy(1'b0, "R1 reset busy");
    for (int i = 0; i < 4; i++) expect_rd(2'(i), "R1 reset line");

    // R2 / R9 / R8 / R12: fill every line through a clean memory load
    for (int i = 0; i < 4; i++) begin
      do_alloc(2'b00, 2'(i), '0, pat(50 + i));
      expect_busy(1'b1, "R2 busy after open");
      expect_rd(2'(i), "R9 stored line before memory");
      do_mem(pat(i + 1));
      expect_rd(2'(i), "R8 memory loads clean buffer");
      do_retire();
      expect_rd(2'(i), "R12 clean buffer written back");
    end

    // R3 / R8 / R10: write-through, memory ignored, masked retire
    do_alloc(2'b01, 2'd1, 64'h00FF_0000_F00F_0001, pat(20));
    do_mem(pat(21));
    expect_rd(2'd1, "R3 write-through overlay, R8 memory ignored");
    do_retire();
    expect_rd(2'd1, "R10 masked bytes stored");

    // R5 / R14: write-through merged over dirty probe data
    do_alloc(2'b01, 2'd2, 64'h8000_0000_0000_0F0C, pat(30));
    do_probe(1'b1, pat(31));
    do_mem(pat(32));
    expect_rd(2'd2, "R5 probe line under write bytes");
    do_retire();
    expect_rd(2'd2, "R14 full merged line stored");

    // R7 / R6 / R12: clean probe no effect, dirty probe replaces, dirty kept
    do_alloc(2'b11, 2'd3, '1, pat(40));
    do_probe(1'b0, pat(41));
    do_mem(pat(42));
    expect_rd(2'd3, "R7 clean probe has no effect");
    do_retire();
    do_alloc(2'b00, 2'd3, '0, '0);
    do_probe(1'b1, pat(43));
    do_probe(1'b1, pat(43));
    do_mem(pat(44));
    expect_rd(2'd3, "R7 dirty probe replaces, R6 repeat kept");
    do_retire();
    expect_rd(2'd3, "R12 dirty buffer not written");

    // R4 / R11: atomic add with wrap
    begin
      logic [511:0] op;
      op = pat(60);
      op[31:0] = 32'hFFFF_FFFF;
      do_alloc(2'b10, 2'd0, 64'h0000_0000_F0F0_00F1, op);
      expect_rd(2'd0, "R4 atomic leaves stored line");
      do_mem(pat(61));
      expect_rd(2'd0, "R8 memory loads buffer under clean atomic");
      do_retire();
      expect_rd(2'd0, "R11 masked word add");
    end

    // R13: inputs while closed, second open while busy
    do_probe(1'b1, pat(70));
    do_mem(pat(71));
    do_retire();
    expect_busy(1'b0, "R13 closed stays closed");
    expect_rd(2'd0, "R13 closed entry ignores events");
    do_alloc(2'b00, 2'd1, '0, '0);
    do_alloc(2'b01, 2'd2, '1, pat(72));
    do_mem(pat(73));
    expect_rd(2'd1, "R13 first open kept");
    expect_rd(2'd2, "R13 second open ignored");
    do_retire();
    expect_rd(2'd1, "R12 clean write back after ignored open");
    expect_rd(2'd2, "R13 line two untouched");

    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule